// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block holds an 8-bit accumulator and a byte-wide status word. On each clock edge where the execute strobe is high, it combines the accumulator with an 8-bit operand under a 4-bit operation code. The operand can be a register value, an immediate or a memory byte. The result normally replaces the accumulator. Compare is the exception: it only changes the flags.

The status byte carries five flags at fixed positions: sign, zero, half carry, parity and carry. Which flags an operation may change depends on its class:
- Arithmetic operations, compare and the bitwise logic operations rewrite all five flags.
- Rotates touch only the carry flag.
- Complement and the plain copy of the operand into the accumulator leave every flag alone.

Results and flags are registered. They appear on the outputs one clock after the strobe.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `acc_o` reads 0x00 and `flags_o` reads 0x00.
- R2: The bit positions in `flags_o` are fixed: bit 7 sign, bit 6 zero, bit 4 half carry, bit 2 parity, bit 0 carry. Bits 5, 3 and 1 always read 0.
- R3: Op 0 (add) and op 1 (add with carry) load the accumulator with the low 8 bits of acc + operand (+ carry flag for op 1). Carry is the ninth sum bit. Half carry is the carry out of bit 3.
- R4: Op 2 (subtract) and op 3 (subtract with borrow) load the accumulator with acc − operand (− carry flag for op 3) in two's complement. Carry is 1 exactly when a borrow occurs. Half carry is the borrow out of bit 3.
- R5: Op 4 (AND), op 5 (OR) and op 6 (XOR) load the accumulator with the bitwise result and clear both carry and half carry.
- R6: Op 7 (compare) sets the flags exactly as op 2 would and leaves the accumulator unchanged. So zero means equal, and carry means the operand is greater than the unsigned accumulator.
- R7: Op 8 (complement) inverts every accumulator bit and leaves the flags unchanged.
- R8: Op 9 rotates the accumulator left and op 10 rotates it right, by one bit. The bit shifted out re-enters at the other end and is also copied into carry. No other flag changes.
- R9: Op 11 (copy) loads the operand into the accumulator and leaves every flag unchanged.
- R10: With `exec_i` low, or with an op code of 12 to 15, neither the accumulator nor the flags change.
- R11: Ops 0 to 7 write the flags from the 8-bit result:
  - sign is result bit 7;
  - zero is 1 when the result is 0x00;
  - parity is 1 when the result has an even number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe: perform `op_i` this cycle |
| op_i | input | 4 | Operation code (see R3 to R10) |
| opd_i | input | 8 | Operand byte |
| acc_o | output | 8 | Accumulator contents |
| flags_o | output | 8 | Packed status flags |

## Verification
The hardest cases to reach are the carry-in paths: add-with-carry and subtract-with-borrow must see a carry flag left set by an earlier instruction. Random op sequences seldom line up a carry out of bit 3 together with a set carry flag. The bench therefore runs directed chains first:
- an overflowing add at 0xFF + 0x01, which sets carry, half carry and zero together, then an add with carry;
- a borrow at 0x00 − 0x01, then a subtract with borrow;
- rotates that move bit 7 or bit 0 into carry.

A long random op stream, including the unused codes and idle cycles, then runs against a reference model kept in the bench.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_i,
  input  logic [3:0] op_i,
  input  logic [7:0] opd_i,
  output logic [7:0] acc_o,
  output logic [7:0] flags_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
                         OP_CPL = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10, OP_LD = 4'd11;

  logic [7:0] acc_q, flg_q, res, nflg;
  logic [8:0] sum, dif;
  logic [4:0] nib_a, nib_s;
  logic       cy, ac, full, wr_acc;
  logic       cin_a, cin_s;

  assign cin_a = (op_i == OP_ADC) & flg_q[0];
  assign cin_s = (op_i == OP_SBB) & flg_q[0];
  assign sum   = {1'b0, acc_q} + {1'b0, opd_i} + {8'd0, cin_a};
  assign nib_a = {1'b0, acc_q[3:0]} + {1'b0, opd_i[3:0]} + {4'd0, cin_a};
  assign dif   = {1'b0, acc_q} - {1'b0, opd_i} - {8'd0, cin_s};
  assign nib_s = {1'b0, acc_q[3:0]} - {1'b0, opd_i[3:0]} - {4'd0, cin_s};

  always_comb begin
    res    = acc_q;
    nflg   = flg_q;
    cy     = 1'b0;
    ac     = 1'b0;
    full   = 1'b0;
    wr_acc = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin res = sum[7:0]; cy = sum[8]; ac = nib_a[4]; full = 1'b1; wr_acc = 1'b1; end
      OP_SUB, OP_SBB: begin res = dif[7:0]; cy = dif[8]; ac = nib_s[4]; full = 1'b1; wr_acc = 1'b1; end
      OP_CMP:         begin res = dif[7:0]; cy = dif[8]; ac = nib_s[4]; full = 1'b1; end
      OP_AND:         begin res = acc_q & opd_i; full = 1'b1; wr_acc = 1'b1; end
      OP_OR:          begin res = acc_q | opd_i; full = 1'b1; wr_acc = 1'b1; end
      OP_XOR:         begin res = acc_q ^ opd_i; full = 1'b1; wr_acc = 1'b1; end
      OP_CPL:         begin res = ~acc_q; wr_acc = 1'b1; end
      OP_ROL:         begin res = {acc_q[6:0], acc_q[7]}; nflg[0] = acc_q[7]; wr_acc = 1'b1; end
      OP_ROR:         begin res = {acc_q[0], acc_q[7:1]}; nflg[0] = acc_q[0]; wr_acc = 1'b1; end
      OP_LD:          begin res = opd_i; wr_acc = 1'b1; end
      default:        ;
    endcase
    if (full)
      nflg = {res[7], (res == 8'h00), 1'b0, ac, 1'b0, ~^res, 1'b0, cy};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 8'h00;
      flg_q <= 8'h00;
    end else if (exec_i) begin
      if (wr_acc) acc_q <= res;
      flg_q <= nflg;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flg_q;

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i || op_i > OP_LD) |=> ($stable(acc_o) && $stable(flags_o)));

  // R9
  copy_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_LD) |=> ($stable(flags_o) && acc_o == $past(opd_i)));

  // R6
  cmp_keep_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CMP) |=> $stable(acc_o));

  // R7
  cpl_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CPL) |=> (acc_o == ~$past(acc_o) && $stable(flags_o)));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i < OP_CMP) |=> (flags_o[6] == (acc_o == 8'h00)));

  // R8
  rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_ROL) |=> (flags_o[0] == acc_o[0] && flags_o[7:1] == $past(flags_o[7:1])));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, exec_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] opd_i = 8'd0;
  logic [7:0] acc_o, flags_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_acc = 8'h00, m_flg = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u0 (.clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
              .opd_i(opd_i), .acc_o(acc_o), .flags_o(flags_o));

  function automatic string tag(input logic [3:0] op, input bit en);
    if (!en || op > 4'd11) return "R10";
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] pack(input logic [7:0] r, input bit h, input bit c);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    return {r[7], r == 8'h00, 1'b0, h, 1'b0, (ones % 2) == 0, 1'b0, c};
  endfunction

  task automatic model(input logic [3:0] op, input logic [7:0] d);
    int a = m_acc, b = d, c = m_flg[0], t;
    logic [7:0] r;
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) c = 0;
        t = a + b + c; r = t[7:0];
        m_flg = pack(r, ((a % 16) + (b % 16) + c) > 15, t > 255); m_acc = r;
      end
      4'd2, 4'd3, 4'd7: begin
        if (op != 4'd3) c = 0;
        t = a - b - c; r = t[7:0];
        m_flg = pack(r, ((a % 16) - (b % 16) - c) < 0, t < 0);
        if (op != 4'd7) m_acc = r;
      end
      4'd4: begin r = m_acc & d; m_flg = pack(r, 0, 0); m_acc = r; end
      4'd5: begin r = m_acc | d; m_flg = pack(r, 0, 0); m_acc = r; end
      4'd6: begin r = m_acc ^ d; m_flg = pack(r, 0, 0); m_acc = r; end
      4'd8: m_acc = ~m_acc;
      4'd9: begin m_flg[0] = m_acc[7]; m_acc = {m_acc[6:0], m_acc[7]}; end
      4'd10: begin m_flg[0] = m_acc[0]; m_acc = {m_acc[0], m_acc[7:1]}; end
      4'd11: m_acc = d;
      default: ;
    endcase
  endtask

  task automatic check(input string rq, input logic [7:0] ea, input logic [7:0] ef);
    n_chk++;
    if (acc_o !== ea || flags_o !== ef) begin
      n_bad++;
      $display("FAIL %s: acc=%h flags=%h expected acc=%h flags=%h", rq, acc_o, flags_o, ea, ef);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] d, input bit en);
    op_i = op; opd_i = d; exec_i = en;
    if (en) model(op, d);
    @(negedge clk);
    exec_i = 1'b0;
    check(tag(op, en), m_acc, m_flg);
    if (flags_o[5] !== 1'b0 || flags_o[3] !== 1'b0 || flags_o[1] !== 1'b0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: flags=%h expected unused bits 0", flags_o);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 8'h00);
    // R3: 0xFF + 0x01 -> 0x00, zero, carry, half carry, parity even
    run(4'd11, 8'hFF, 1'b1);
    run(4'd0, 8'h01, 1'b1);
    check("R2", 8'h00, 8'b0101_0101);
    run(4'd1, 8'h10, 1'b1);            // R3: carry-in adds 1
    check("R3", 8'h11, 8'h04);
    // R4: borrow then subtract with borrow
    run(4'd11, 8'h00, 1'b1);
    run(4'd2, 8'h01, 1'b1);
    check("R4", 8'hFF, 8'b1001_0101);
    run(4'd3, 8'h0F, 1'b1);
    // R6: equal and operand greater
    run(4'd11, 8'h42, 1'b1);
    run(4'd7, 8'h42, 1'b1);
    check("R6", 8'h42, 8'b0100_0100);
    run(4'd7, 8'h43, 1'b1);
    // R8: rotates through the end bits
    run(4'd11, 8'h81, 1'b1);
    run(4'd9, 8'h00, 1'b1);
    run(4'd10, 8'h00, 1'b1);
    run(4'd10, 8'h00, 1'b1);
    // R7, R9, R10: flags untouched
    run(4'd8, 8'h00, 1'b1);
    run(4'd11, 8'h00, 1'b1);
    run(4'd14, 8'h55, 1'b1);
    run(4'd0, 8'h77, 1'b0);
    // R5: logic clears carries; R11 parity/sign
    run(4'd11, 8'hF0, 1'b1);
    run(4'd5, 8'h0F, 1'b1);
    run(4'd4, 8'h3C, 1'b1);
    run(4'd6, 8'h3C, 1'b1);
    for (int i = 0; i < 4000; i++)
      run(4'($urandom % 16), 8'($urandom), ($urandom % 8) != 0);
    finish_up();
  end
endmodule